// File: doc/BRIEF.md
# Hamming SEC-DED Codec

This block guards a 16-bit word with a 22-bit single-error-correcting, double-error-detecting code. A combinational encoder places the data bits at the non-power-of-two positions of a 21-position Hamming vector. It fills the power-of-two positions with check bits and adds one overall parity bit at position 0.

The decoder accepts a codeword with a valid strobe and recomputes a 5-bit syndrome and the overall parity. One clock later it presents the data word together with one of four mutually exclusive status flags:
- a data bit was in error and has been repaired;
- a single check bit was in error;
- the overall parity bit alone was in error;
- the word holds an uncorrectable multi-bit error.

Top module: `hamming_secded_codec`

## Requirements
- R1: Encoder layout: codeword bit 0 is the overall parity bit. Check bit k (k = 0..4) sits at position 2^k (1, 2, 4, 8, 16) and is the XOR of every other position 1..21 whose index has bit k set. Data bit i sits at the i-th position in ascending order of 3, 5, 6, 7, 9..15, 17..21.
- R2: The XOR of all 22 bits of every encoder output is 0 (even overall parity).
- R3: outValid is high exactly in the cycle after a cycle with decValid high. While decValid is low, outData and all flags keep their last values.
- R4: An intact codeword yields its data field on outData with all four flags low.
- R5: A single flipped data position (syndrome names a non-power-of-two position 3..21 and overall parity fails) is corrected. Only dataErr is set.
- R6: A single flipped check bit (syndrome a power of two, overall parity fails) sets only checkErr. The data field passes unchanged.
- R7: A flipped overall parity bit (syndrome zero, overall parity fails) sets only parErr. The data field passes unchanged.
- R8: Two flipped bits (syndrome nonzero, overall parity good) set only dblErr. outData is the received data field, uncorrected.
- R9: A failing overall parity with a syndrome above 21 sets only dblErr and corrects nothing.
- R10: At most one of dataErr, checkErr, parErr, dblErr is high at any time.
- R11: While rstN is low, outValid, outData and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| encData | input | 16 | Data word to encode |
| encCode | output | 22 | Encoded codeword (combinational) |
| decValid | input | 1 | decCode is valid this cycle |
| decCode | input | 22 | Received codeword to check |
| outValid | output | 1 | Registered result valid |
| outData | output | 16 | Corrected or passed data word |
| dataErr | output | 1 | Single data-bit error repaired |
| checkErr | output | 1 | Single check-bit error |
| parErr | output | 1 | Overall parity bit error |
| dblErr | output | 1 | Uncorrectable error |

## Verification
The assertions assume decValid and decCode are known whenever reset is released, and that encData is always driven. The bench therefore drives every input from time zero, changing them only on the falling edge. Corrupted words are formed from correct encodings with at most three flips, so each case maps onto exactly one status class the bench can predict. The three-flip cases are chosen so that their syndrome lands above 21.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
  localparam int DATA_W  = 16;
  localparam int CHK_W   = 5;
  localparam int CODE_W  = DATA_W + CHK_W + 1;
  localparam int MAX_POS = CODE_W - 1;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CHK_W-1:0]  syn_t;

  // strobes from the classifier to the datapath
  typedef struct packed {
    logic capture;
    logic correct;
    logic flagData;
    logic flagCheck;
    logic flagPar;
    logic flagDbl;
  } dec_ctrl_t;

  function automatic logic isPow2(int p);
    return (p != 0) && ((p & (p - 1)) == 0);
  endfunction

  // position of data bit idx inside the codeword
  function automatic int dataPos(int idx);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 1; p <= MAX_POS; p++) begin
      if (!isPow2(p)) begin
        if (cnt == idx) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  function automatic code_t placeData(data_t d);
    code_t c;
    c = '0;
    for (int i = 0; i < DATA_W; i++) c[dataPos(i)] = d[i];
    return c;
  endfunction

  function automatic data_t pickData(code_t c);
    data_t d;
    for (int i = 0; i < DATA_W; i++) d[i] = c[dataPos(i)];
    return d;
  endfunction

  function automatic syn_t syndromeOf(code_t c);
    syn_t s;
    s = '0;
    for (int p = 1; p <= MAX_POS; p++) begin
      for (int k = 0; k < CHK_W; k++) begin
        if (((p >> k) & 1) == 1) s[k] = s[k] ^ c[p];
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/hsd_encoder.sv
module hsd_encoder
  import hsd_pkg::*;
(
  input  data_t dataIn,
  output code_t codeOut
);
  code_t placed;
  syn_t  chk;
  code_t withChk;

  always_comb begin
    placed = placeData(dataIn);
    chk    = syndromeOf(placed);
  end

  genvar k;
  generate
    for (k = 0; k < CHK_W; k++) begin : g_chk
      assign withChk[1 << k] = chk[k];
    end
    for (k = 1; k <= MAX_POS; k++) begin : g_dat
      if (!isPow2(k)) begin : g_copy
        assign withChk[k] = placed[k];
      end
    end
  endgenerate

  assign withChk[0] = ^withChk[CODE_W-1:1];
  assign codeOut    = withChk;
endmodule

// File: rtl/hsd_control.sv
module hsd_control
  import hsd_pkg::*;
(
  input  logic      valid,
  input  syn_t      syn,
  input  logic      overallFail,
  output dec_ctrl_t ctrl
);
  int synPos;

  always_comb begin
    synPos = int'(syn);
    ctrl   = '0;
    ctrl.capture = valid;
    if (overallFail) begin
      if (synPos == 0)            ctrl.flagPar   = 1'b1;
      else if (synPos > MAX_POS)  ctrl.flagDbl   = 1'b1;
      else if (isPow2(synPos))    ctrl.flagCheck = 1'b1;
      else begin
        ctrl.flagData = 1'b1;
        ctrl.correct  = 1'b1;
      end
    end else if (synPos != 0) begin
      ctrl.flagDbl = 1'b1;
    end
  end
endmodule

// File: rtl/hsd_datapath.sv
module hsd_datapath
  import hsd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  code_t     codeIn,
  input  dec_ctrl_t ctrl,
  output syn_t      syn,
  output logic      overallFail,
  output logic      outValid,
  output data_t     outData,
  output logic      dataErr,
  output logic      checkErr,
  output logic      parErr,
  output logic      dblErr
);
  code_t flipVec;
  data_t rawData;
  data_t corrData;

  assign syn         = syndromeOf(codeIn);
  assign overallFail = ^codeIn;
  assign rawData     = pickData(codeIn);
  assign flipVec     = ctrl.correct ? (code_t'(1) << syn) : '0;
  assign corrData    = pickData(codeIn ^ flipVec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      dataErr  <= 1'b0;
      checkErr <= 1'b0;
      parErr   <= 1'b0;
      dblErr   <= 1'b0;
    end else begin
      outValid <= ctrl.capture;
      if (ctrl.capture) begin
        outData  <= corrData;
        dataErr  <= ctrl.flagData;
        checkErr <= ctrl.flagCheck;
        parErr   <= ctrl.flagPar;
        dblErr   <= ctrl.flagDbl;
      end
    end
  end

  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |=> outValid);
  // R3
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> !outValid);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> ($stable(outData) && $stable(dblErr) && $stable(dataErr)));
  // R10
  flag_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dataErr, checkErr, parErr, dblErr}));
  // R8
  dbl_nocorrect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.capture && ctrl.flagDbl) |=> (outData == $past(rawData)));
endmodule

// File: rtl/hamming_secded_codec.sv
module hamming_secded_codec
  import hsd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] encData,
  output logic [CODE_W-1:0] encCode,
  input  logic              decValid,
  input  logic [CODE_W-1:0] decCode,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              dataErr,
  output logic              checkErr,
  output logic              parErr,
  output logic              dblErr
);
  dec_ctrl_t ctrl;
  syn_t      syn;
  logic      overallFail;

  hsd_encoder u_enc (
    .dataIn  (encData),
    .codeOut (encCode)
  );

  hsd_control u_ctl (
    .valid       (decValid),
    .syn         (syn),
    .overallFail (overallFail),
    .ctrl        (ctrl)
  );

  hsd_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .codeIn      (decCode),
    .ctrl        (ctrl),
    .syn         (syn),
    .overallFail (overallFail),
    .outValid    (outValid),
    .outData     (outData),
    .dataErr     (dataErr),
    .checkErr    (checkErr),
    .parErr      (parErr),
    .dblErr      (dblErr)
  );

  // R2
  enc_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (^encCode) == 1'b0);
  // R1
  enc_syndrome_chk: assert property (@(posedge clk) disable iff (!rstN)
    syndromeOf(encCode) == '0);
endmodule

// File: tb/hamming_secded_codec_tb.sv
module hamming_secded_codec_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] data;
    logic [21:0] mask;
    logic [2:0]  cls;   // 0 clean, 1 data, 2 check, 3 parity, 4 double
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{16'h0000, 22'h000000, 3'd0},
    '{16'hFFFF, 22'h000000, 3'd0},
    '{16'hA5C3, 22'h000008, 3'd1},
    '{16'h1234, 22'h200000, 3'd1},
    '{16'hBEEF, 22'h001000, 3'd1},
    '{16'h5555, 22'h000002, 3'd2},
    '{16'h5555, 22'h010000, 3'd2},
    '{16'h8001, 22'h000001, 3'd3},
    '{16'h0F0F, 22'h000028, 3'd4},
    '{16'hCAFE, 22'h000081, 3'd4},
    '{16'h7777, 22'h010102, 3'd4},
    '{16'h3C3C, 22'h20000A, 3'd4},
    '{16'hFFFF, 22'h000014, 3'd4}
  };

  localparam int POS_TBL [16] = '{3, 5, 6, 7, 9, 10, 11, 12, 13, 14, 15,
                                  17, 18, 19, 20, 21};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] encData = '0;
  logic [21:0] encCode;
  logic        decValid = 1'b0;
  logic [21:0] decCode = '0;
  logic        outValid;
  logic [15:0] outData;
  logic        dataErr, checkErr, parErr, dblErr;

  int tests = 0;
  int failed = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hamming_secded_codec dut_i (
    .clk(clk), .rstN(rstN), .encData(encData), .encCode(encCode),
    .decValid(decValid), .decCode(decCode), .outValid(outValid),
    .outData(outData), .dataErr(dataErr), .checkErr(checkErr),
    .parErr(parErr), .dblErr(dblErr)
  );

  function automatic logic [21:0] modelEnc(logic [15:0] d);
    logic [21:0] c;
    c = '0;
    for (int i = 0; i < 16; i++) c[POS_TBL[i]] = d[i];
    for (int k = 0; k < 5; k++) begin
      logic acc;
      acc = 1'b0;
      for (int p = 1; p < 22; p++)
        if (p != (1 << k) && ((p >> k) & 1) == 1) acc ^= c[p];
      c[1 << k] = acc;
    end
    c[0] = ^c[21:1];
    return c;
  endfunction

  function automatic logic [15:0] modelPick(logic [21:0] c);
    logic [15:0] d;
    for (int i = 0; i < 16; i++) d[i] = c[POS_TBL[i]];
    return d;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkFlags(string req, logic [3:0] exp);
    chk(req, {28'd0, dataErr, checkErr, parErr, dblErr}, {28'd0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failed++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    logic [21:0] code;
    logic [15:0] expData;
    logic [3:0]  expFlags;
    logic [15:0] heldData;
    logic [3:0]  heldFlags;

    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 outValid in reset", {31'd0, outValid}, 32'd0);
    chk("R11 outData in reset", {16'd0, outData}, 32'd0);
    chkFlags("R11 flags in reset", 4'b0000);
    rstN = 1'b1;
    @(negedge clk);
    chk("R3 no valid after reset", {31'd0, outValid}, 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      encData = VEC[v].data;
      #1;
      // R1 R2 encoder
      chk("R1 encoder codeword", {10'd0, encCode}, {10'd0, modelEnc(VEC[v].data)});
      chk("R2 encoder parity", {31'd0, ^encCode}, 32'd0);
      @(negedge clk);
      code     = modelEnc(VEC[v].data) ^ VEC[v].mask;
      decCode  = code;
      decValid = 1'b1;
      @(negedge clk);
      decValid = 1'b0;
      expData  = (VEC[v].cls == 3'd4) ? modelPick(code) : VEC[v].data;
      case (VEC[v].cls)
        3'd1:    expFlags = 4'b1000;
        3'd2:    expFlags = 4'b0100;
        3'd3:    expFlags = 4'b0010;
        3'd4:    expFlags = 4'b0001;
        default: expFlags = 4'b0000;
      endcase
      chk("R3 outValid after strobe", {31'd0, outValid}, 32'd1);
      case (VEC[v].cls)
        3'd0: begin
          chk("R4 clean data", {16'd0, outData}, {16'd0, expData});
          chkFlags("R4 clean flags", expFlags);
        end
        3'd1: begin
          chk("R5 corrected data", {16'd0, outData}, {16'd0, expData});
          chkFlags("R5 data error flags", expFlags);
        end
        3'd2: begin
          chk("R6 check error data", {16'd0, outData}, {16'd0, expData});
          chkFlags("R6 check error flags", expFlags);
        end
        3'd3: begin
          chk("R7 parity error data", {16'd0, outData}, {16'd0, expData});
          chkFlags("R7 parity error flags", expFlags);
        end
        default: begin
          if ($countones(VEC[v].mask) == 3) begin
            chk("R9 high syndrome data", {16'd0, outData}, {16'd0, expData});
            chkFlags("R9 high syndrome flags", expFlags);
          end else begin
            chk("R8 double error data", {16'd0, outData}, {16'd0, expData});
            chkFlags("R8 double error flags", expFlags);
          end
        end
      endcase
      chk("R10 at most one flag",
          {31'd0, ($countones({dataErr, checkErr, parErr, dblErr}) <= 1)}, 32'd1);
    end

    // R3 hold while decValid low: follow a double error with an intact word
    decCode  = modelEnc(16'h0F0F) ^ 22'h000028;
    decValid = 1'b1;
    @(negedge clk);
    decValid  = 1'b0;
    heldData  = outData;
    heldFlags = {dataErr, checkErr, parErr, dblErr};
    decCode   = modelEnc(16'h1111);
    @(negedge clk);
    chk("R3 outValid low when idle", {31'd0, outValid}, 32'd0);
    chk("R3 data held when idle", {16'd0, outData}, {16'd0, heldData});
    chk("R3 flags held when idle", {28'd0, dataErr, checkErr, parErr, dblErr},
        {28'd0, heldFlags});

    // R11 reset in mid run
    rstN = 1'b0;
    @(negedge clk);
    chk("R11 outData cleared", {16'd0, outData}, 32'd0);
    chkFlags("R11 flags cleared", 4'b0000);
    rstN = 1'b1;
    @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule